// File: doc/BRIEF.md
# Two-Phase 8-bit Microcontroller Core

A compact 8-bit processor that executes 18-bit instruction words from an internal, computed 1024-word program store. Its state is sixteen 8-bit working registers, a 10-bit program counter, and zero and carry flags. Every instruction takes two clock cycles: a fetch cycle that latches the word addressed by the program counter, then an execute cycle that updates registers, flags and the program counter.

Peripherals are reached through an 8-bit port address. The port number comes either from the instruction's constant field or from a second register. A read strobe marks the cycle in which the input bus is written into a register, and a write strobe marks the cycle in which the output bus is valid. The built-in program reads two operands from ports 0 and 1 and multiplies them by shift-and-add, writing the product to port 2. It then runs a short self-test sequence on a third input read from port 3 before it halts in a self-loop.

Top module: `tiny8_core`

## Requirements
- R1: While `rst_n` is low, `rd_stb`, `wr_stb`, `io_addr` and `dout` are 0. After release, the program counter, both flags and all sixteen registers start at 0. The first instruction executes in the second cycle after release.
- R2: Every instruction takes exactly two cycles, fetch then execute. `rd_stb` and `wr_stb` are asserted only in an execute cycle and never for two cycles in a row. Instruction n (counting from 0, with no earlier jumps) executes in cycle 2n+1 after reset.
- R3: The word format is opcode in bits 17:12, destination register in 11:8, and constant or port in 7:0. In register form, the source register is in 7:4. Opcode bit 12 = 1 selects the register form. LOAD (000000 constant, 000001 register) copies the operand and leaves both flags unchanged.
- R4: AND (001010/001011) and OR (001100/001101) write the bitwise result and clear carry. Zero is set when the result is 0.
- R5: ADD (011000/011001) writes the low 8 bits of the sum and puts the carry-out of bit 7 into carry. ADDCY (011010/011011) also adds the incoming carry. Zero is set when the 8-bit result is 0.
- R6: COMPARE (010100/010101) writes no register. It sets carry when the destination is below the operand (unsigned) and sets zero when the two are equal.
- R7: Opcode 100000 is a shift of the destination register. Bits 3:0 = 1110 shifts right with 0 entering bit 7, and 0110 shifts left with 0 entering bit 0. The bit shifted out goes to carry, and zero reflects the result.
- R8: Opcode 110100 jumps to bits 9:0 unconditionally. Opcode 110101 jumps only when the condition in bits 11:10 holds: 00 zero set, 01 zero clear, 10 carry set, 11 carry clear. Otherwise the program counter advances by 1. Jumps change no flag.
- R9: INPUT (000100 port constant, 000101 port from source register) drives `io_addr` and `rd_stb` in the execute cycle and writes `din` into the destination register. Flags are unchanged.
- R10: OUTPUT (101100 port constant, 101101 port from source register) drives `io_addr`, `wr_stb` and `dout` = destination register in the execute cycle. Flags are unchanged. Outside a write, `dout` is 0.
- R11: The built-in program writes, in this order:
  - (a*b) mod 256 to port 2;
  - (c AND 0Fh) OR 30h to port 4;
  - (c+80h) mod 256 to port 5;
  - 1 plus the carry of that addition to port 6;
  - 11h if c < 40h, else 22h, to port 7;
  - c to port 8, with the port number taken from a register.

  Here a, b and c are read from ports 0, 1 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 8 | Input data bus, sampled on an INPUT execute cycle |
| io_addr | output | 8 | Port number during a read or write strobe, else 0 |
| rd_stb | output | 1 | One-cycle read strobe |
| wr_stb | output | 1 | One-cycle write strobe |
| dout | output | 8 | Output data, valid with `wr_stb` |

## Verification
Port writes appear in the execute cycle of an OUTPUT. With no jumps taken before it, instruction n reaches that point 2n+1 cycles after reset release. The bench therefore counts cycles from release and checks that the first read happens in cycle 1 and, for a zero multiplier, that the product write happens in cycle 11. All port traffic is captured on the falling edge, half a cycle after the strobe rises, so each captured value belongs to the execute cycle that produced it. Result values are checked only after the final write to port 8 has been seen. Flag and register effects are observed through the values the program later writes out.

// File: rtl/tiny8_core.sv
module tiny8_core #(
  parameter int AW   = 10,
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] io_addr,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] dout
);
  localparam int IW = 18;
  localparam int RW = $clog2(NREG);

  function automatic logic [IW-1:0] rom_word(input logic [AW-1:0] a);
    case (int'(a))
      0:  rom_word = {6'b000100, 4'h0, 8'h00};          // INPUT s0,0
      1:  rom_word = {6'b000100, 4'h1, 8'h01};          // INPUT s1,1
      2:  rom_word = {6'b000000, 4'h2, 8'h00};          // LOAD s2,0
      3:  rom_word = {6'b010100, 4'h1, 8'h00};          // COMPARE s1,0
      4:  rom_word = {6'b110101, 2'b00, 10'h00A};       // JUMP Z
      5:  rom_word = {6'b100000, 4'h1, 4'h0, 4'b1110};  // SR0 s1
      6:  rom_word = {6'b110101, 2'b11, 10'h008};       // JUMP NC
      7:  rom_word = {6'b011001, 4'h2, 4'h0, 4'h0};     // ADD s2,s0
      8:  rom_word = {6'b100000, 4'h0, 4'h0, 4'b0110};  // SL0 s0
      9:  rom_word = {6'b110100, 2'b00, 10'h003};       // JUMP
      10: rom_word = {6'b101100, 4'h2, 8'h02};          // OUTPUT s2,2
      11: rom_word = {6'b000100, 4'h4, 8'h03};          // INPUT s4,3
      12: rom_word = {6'b000001, 4'h5, 4'h4, 4'h0};     // LOAD s5,s4
      13: rom_word = {6'b001010, 4'h5, 8'h0F};          // AND s5,0F
      14: rom_word = {6'b001100, 4'h5, 8'h30};          // OR s5,30
      15: rom_word = {6'b101100, 4'h5, 8'h04};          // OUTPUT s5,4
      16: rom_word = {6'b000001, 4'h6, 4'h4, 4'h0};     // LOAD s6,s4
      17: rom_word = {6'b011000, 4'h6, 8'h80};          // ADD s6,80
      18: rom_word = {6'b000000, 4'h7, 8'h00};          // LOAD s7,0
      19: rom_word = {6'b011010, 4'h7, 8'h01};          // ADDCY s7,1
      20: rom_word = {6'b101100, 4'h6, 8'h05};          // OUTPUT s6,5
      21: rom_word = {6'b101100, 4'h7, 8'h06};          // OUTPUT s7,6
      22: rom_word = {6'b010100, 4'h4, 8'h40};          // COMPARE s4,40
      23: rom_word = {6'b000000, 4'h8, 8'h11};          // LOAD s8,11
      24: rom_word = {6'b110101, 2'b10, 10'h01A};       // JUMP C
      25: rom_word = {6'b000000, 4'h8, 8'h22};          // LOAD s8,22
      26: rom_word = {6'b101100, 4'h8, 8'h07};          // OUTPUT s8,7
      27: rom_word = {6'b000000, 4'h9, 8'h08};          // LOAD s9,8
      28: rom_word = {6'b101101, 4'h4, 4'h9, 4'h0};     // OUTPUT s4,(s9)
      29: rom_word = {6'b110100, 2'b00, 10'h01D};       // JUMP self
      default: rom_word = {6'b110100, 2'b00, 10'h01D};
    endcase
  endfunction

  logic [AW-1:0] pc;
  logic [IW-1:0] ir;
  logic          exec;
  logic          cf, zf;
  logic [DW-1:0] rf [NREG];

  wire [5:0]    op  = ir[17:12];
  wire [RW-1:0] xa  = ir[8 +: RW];
  wire [DW-1:0] sx  = rf[xa];
  wire [DW-1:0] sy  = rf[ir[4 +: RW]];
  wire [DW-1:0] opb = ir[12] ? sy : ir[7:0];

  logic          wr_en, upd_f, take, is_in, is_out;
  logic [DW-1:0] res;
  logic          c_nx;
  logic [DW:0]   sum;

  always_comb begin
    wr_en = 1'b0; upd_f = 1'b0; take = 1'b0; is_in = 1'b0; is_out = 1'b0;
    res = '0; c_nx = cf; sum = '0;
    case (op[5:1])
      5'b00000: begin wr_en = 1'b1; res = opb; end
      5'b00010: begin wr_en = 1'b1; res = din; is_in = 1'b1; end
      5'b00101: begin wr_en = 1'b1; upd_f = 1'b1; res = sx & opb; c_nx = 1'b0; end
      5'b00110: begin wr_en = 1'b1; upd_f = 1'b1; res = sx | opb; c_nx = 1'b0; end
      5'b01010: begin
        upd_f = 1'b1; sum = {1'b0, sx} - {1'b0, opb};
        res = sum[DW-1:0]; c_nx = sum[DW];
      end
      5'b01100, 5'b01101: begin
        wr_en = 1'b1; upd_f = 1'b1;
        sum = {1'b0, sx} + {1'b0, opb} + {{DW{1'b0}}, op[1] & cf};
        res = sum[DW-1:0]; c_nx = sum[DW];
      end
      5'b10110: is_out = 1'b1;
      5'b10000: if (!op[0] && ir[2:0] == 3'b110) begin
        wr_en = 1'b1; upd_f = 1'b1;
        if (ir[3]) begin res = {1'b0, sx[DW-1:1]}; c_nx = sx[0]; end
        else       begin res = {sx[DW-2:0], 1'b0}; c_nx = sx[DW-1]; end
      end
      5'b11010: begin
        if (!op[0]) take = 1'b1;
        else case (ir[11:10])
          2'b00: take = zf;
          2'b01: take = !zf;
          2'b10: take = cf;
          default: take = !cf;
        endcase
      end
      default: ;
    endcase
  end

  wire [AW-1:0] pc_nx = take ? ir[AW-1:0] : pc + 1'b1;

  assign rd_stb  = exec & is_in;
  assign wr_stb  = exec & is_out;
  assign io_addr = (rd_stb | wr_stb) ? opb : '0;
  assign dout    = wr_stb ? sx : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; ir <= '0; exec <= 1'b0; cf <= 1'b0; zf <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (!exec) begin
      ir   <= rom_word(pc);
      exec <= 1'b1;
    end else begin
      exec <= 1'b0;
      pc   <= pc_nx;
      if (wr_en) rf[xa] <= res;
      if (upd_f) begin
        cf <= c_nx;
        zf <= (res == '0);
      end
    end
  end

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_stb |=> !rd_stb);
  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb);
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !take) |=> (pc == $past(pc) + 1'b1));
  // R8
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && take) |=> (pc == $past(ir[AW-1:0])));
  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !upd_f) |=> ($stable(cf) && $stable(zf)));
  // R6
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op[5:1] == 5'b01010) |=> $stable(sx));
endmodule

// File: tb/tiny8_core_tb.sv
`timescale 1ns/1ps
module tiny8_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] din, io_addr, dout;
  logic rd_stb, wr_stb;
  logic [7:0] a_v, b_v, c_v;

  always #2.5 clk = ~clk;

  assign din = !rd_stb ? 8'h00 : (io_addr == 8'd0) ? a_v :
               (io_addr == 8'd1) ? b_v : (io_addr == 8'd3) ? c_v : 8'hEE;

  tiny8_core dut_i (.clk(clk), .rst_n(rst_n), .din(din), .io_addr(io_addr),
                    .rd_stb(rd_stb), .wr_stb(wr_stb), .dout(dout));

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [7:0] got [16];
  logic [15:0] seen;
  int out2_cyc, first_rd_cyc, bad_rd, both_stb;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      seen = '0; out2_cyc = -1; first_rd_cyc = -1; bad_rd = 0; both_stb = 0;
    end else begin
      if (wr_stb) begin
        got[io_addr[3:0]] = dout;
        seen[io_addr[3:0]] = 1'b1;
        if (io_addr == 8'd2 && out2_cyc < 0) out2_cyc = cyc;
      end
      if (rd_stb) begin
        if (first_rd_cyc < 0) first_rd_cyc = cyc;
        if (io_addr != 8'd0 && io_addr != 8'd1 && io_addr != 8'd3) bad_rd++;
      end
      if (rd_stb && wr_stb) both_stb++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    int t;
    a_v = a; b_v = b; c_v = c;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle during reset
    check("R1 reset outputs", {rd_stb, wr_stb, io_addr, dout}, 0);
    rst_n = 1'b1;
    t = 0;
    while (!seen[8] && t < 3000) begin @(negedge clk); t++; end
    if (!seen[8]) check("R11 timeout", 0, 1);
    repeat (4) @(negedge clk);
  endtask

  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {8'd13, 8'd5,  8'h00}, {8'd15, 8'd15, 8'h3F}, {8'd0, 8'd9, 8'h40},
    {8'd1,  8'd1,  8'h7F}, {8'd12, 8'd10, 8'h80}, {8'd9, 8'd14, 8'hFF},
    {8'd7,  8'd3,  8'hC5}};

  initial begin
    for (int i = 0; i < NV; i++) begin
      logic [7:0] a, b, c;
      logic [8:0] s;
      {a, b, c} = VEC[i];
      run(a, b, c);
      s = {1'b0, c} + 9'h080;
      check("R11 R5 product port2", got[2], (a * b) & 8'hFF);
      check("R4 and/or port4", got[4], (c & 8'h0F) | 8'h30);
      check("R5 add port5", got[5], s[7:0]);
      check("R5 addcy port6", got[6], 1 + s[8]);
      check("R6 R8 compare/jump C port7", got[7], (c < 8'h40) ? 8'h11 : 8'h22);
      check("R10 reg-port output port8", got[8], c);
      check("R9 read ports", bad_rd, 0);
      check("R2 strobe exclusive", both_stb, 0);
    end
    // R7 R8: zero multiplier skips loop, product written as instruction 5 in cycle 11
    run(8'd6, 8'd0, 8'h12);
    check("R2 R8 port2 write cycle", out2_cyc, 11);
    check("R7 zero product", got[2], 0);
    // R1 R9: first read of port 0 in cycle 1
    check("R1 R9 first read cycle", first_rd_cyc, 1);
    // R7: shift of an 8-bit multiplier past bit 4
    run(8'd3, 8'd85, 8'h01);
    check("R7 shift multiply", got[2], (3 * 85) & 8'hFF);
    // R3: LOAD keeps carry from COMPARE (c<40h path)
    check("R3 load keeps flags", got[7], 8'h11);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule